// File: doc/BRIEF.md
# One-Time-Programmable Memory Write Sequencer

This block sits inside a device programmer and writes a byte-wide one-time-programmable memory with an adaptive pulse-and-verify algorithm. An erased cell reads as one, and a program pulse can only clear bits to zero. The sequencer starts at address zero. For each byte it applies fixed-width program pulses, and after each pulse it reads the byte back. It stops pulsing when the byte matches or when the attempt cap is reached. After a match it applies a single over-program pulse whose length is the number of attempts the byte needed times the base pulse width. It then moves to the next address.

The sequencer raises a flag that asks the external supply circuitry for the high programming levels. It changes this flag only while the chip enable is inactive. Once the last address is programmed, it drops the flag, waits for the supplies to settle, and reads every location back under normal read conditions. Any mismatch fails the run. The data to be written comes from a source port indexed by the current address. A run starts with a one-cycle `start` and ends with a one-cycle `done`, and `pass` carries the result.

All timings are cycle counts. They are derived from the clock frequency and the nanosecond parameters: base pulse width, setup/hold time and read access time.

Top module: `otp_prog_seq`

## Requirements
- R1: After reset the block is idle: `mem_ce_n`, `mem_oe_n` and `mem_pgm_n` are 1, `hi_supply`, `done` and `pass` are 0.
- R2: A `start` pulse while idle begins programming at address 0. `src_addr` always equals `mem_addr`, and `hi_supply` is 1 for the whole programming phase.
- R3: A program pulse has `mem_ce_n`=0, `mem_oe_n`=1, `mem_pgm_n`=0 and `mem_data_oe`=1. It is at least the base width (PW cycles), and address and data stay unchanged during it. Before each pulse, the chip is enabled with output disabled and address and data stable for at least the setup count (SU cycles). Data drive and chip enable are also held for SU cycles after the pulse.
- R4: A verify or read access has `mem_ce_n`=0, `mem_oe_n`=0, `mem_pgm_n`=1 and `mem_data_oe`=0. The byte is compared with `src_data` after the access count of cycles.
- R5: Each attempt is exactly one pulse of PW cycles followed by a verify. A mismatch below the cap leads to another attempt.
- R6: When the verify passes at attempt n, exactly one further pulse of n·PW cycles follows, and then the address advances. A byte therefore receives n+1 pulses. A byte whose target is 0xFF passes at n=1.
- R7: The attempt count never exceeds MAX_TRY (25). A mismatch at attempt MAX_TRY ends the run with `pass`=0. It applies no over-program pulse and does no final read.
- R8: `hi_supply` changes only while `mem_ce_n` is 1 in both the current and the previous cycle. After the last address, `hi_supply` is 0, no further pulses occur, and addresses 0..LAST_ADDR are read in ascending order.
- R9: `done` is high for exactly one cycle per run. `pass` is 1 only if every byte programmed within the cap and every final read matched, and it holds its value until the next `start`. The final read stops at the first mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle run request, accepted while idle |
| done | output | 1 | One-cycle end-of-run strobe |
| pass | output | 1 | Result of the last run (1 = success) |
| src_addr | output | AW | Address presented to the data source |
| src_data | input | DW | Target byte for `src_addr` |
| mem_addr | output | AW | Memory address pins |
| mem_din | output | DW | Data driven to the memory during programming |
| mem_dout | input | DW | Data read back from the memory |
| mem_data_oe | output | 1 | Enables the programmer's data driver |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_pgm_n | output | 1 | Program strobe, active low |
| hi_supply | output | 1 | Requests programming supply levels |

## Verification
The bench pairs the sequencer with a memory model that needs a chosen number of pulses per byte. It looks at the attempt-count corners: a byte that matches on its first attempt, including one whose target is already 0xFF, a byte that needs exactly 25 attempts, and one that needs 26. A design with an off-by-one cap would either fail the 25-attempt byte or over-program the 26-attempt one. A design that scales the over-program pulse by the wrong count shows up as a last-pulse length other than n·PW, or a pulse total other than n+1. A model that corrupts one byte only under read conditions catches a sequencer that skips the final read or reports success in spite of it. The read-order check shows whether the sequencer stops at the first mismatch.

// File: rtl/otp_seq_pkg.sv
// Shared types and helpers for the OTP write sequencer.
// Assumes clock frequency is given in kHz and durations in ns.
package otp_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RAMP,
        S_PSETUP,
        S_PULSE,
        S_PHOLD,
        S_VERIFY,
        S_RAMPDN,
        S_RSETTLE,
        S_RREAD,
        S_FINISH
    } seq_state_t;

    // Round a duration up to whole clock cycles, never below one.
    function automatic int ns_to_cycles(longint clk_khz, longint dur_ns);
        longint c;
        c = (clk_khz * dur_ns + 64'd999999) / 64'd1000000;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

endpackage

// File: rtl/otp_timer.sv
// Down-counting interval timer. A load sets the count to (duration - 1);
// zero is high in the last cycle of the interval. Assumes loads only
// happen on state transitions of the controlling sequencer.
module otp_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt;

    // Load on request, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/otp_try_ctr.sv
// Per-byte attempt counter with a saturating cap. Assumes clear and
// increment are never requested in the same cycle.
module otp_try_ctr #(
    parameter int MAX_TRY = 25,
    parameter int W       = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count,
    output logic         at_cap
);

    // Clear per byte, count attempts, never pass the cap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc && (count != W'(MAX_TRY))) begin
            count <= count + 1'b1;
        end
    end

    assign at_cap = (count == W'(MAX_TRY));

endmodule

// File: rtl/otp_seq_fsm.sv
// Sequencing state machine: pulse/verify loop per byte, over-program
// pulse scaled by the attempt count, supply ramp states that keep the
// chip disabled, and a final read-back pass. Assumes the memory read
// data is valid once the access interval has elapsed.
module otp_seq_fsm
    import otp_seq_pkg::*;
#(
    parameter int AW        = 17,
    parameter int TW        = 18,
    parameter int NW        = 5,
    parameter int LAST_ADDR = 131071,
    parameter int PW_CYC    = 10000,
    parameter int SET_CYC   = 100,
    parameter int ACC_CYC   = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          tmr_zero,
    input  logic          at_cap,
    input  logic [NW-1:0] tries,
    input  logic          match,
    output seq_state_t    st,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output logic          try_clr,
    output logic          try_inc,
    output logic [AW-1:0] addr,
    output logic          pass
);

    localparam logic [TW-1:0] PW_M1  = TW'(PW_CYC - 1);
    localparam logic [TW-1:0] SET_M1 = TW'(SET_CYC - 1);
    localparam logic [TW-1:0] ACC_M1 = TW'(ACC_CYC - 1);

    seq_state_t    nxt;
    logic          ovr;
    logic          pass_r;
    logic          addr_clr, addr_inc;
    logic          ovr_set, ovr_clr;
    logic          fail;
    logic          last;
    logic [TW-1:0] over_m1;

    assign last    = (addr == AW'(LAST_ADDR));
    assign over_m1 = TW'(tries) * TW'(PW_CYC) - 1'b1;

    // Next state, timer loads and counter controls.
    always_comb begin
        nxt      = st;
        tmr_load = 1'b0;
        tmr_val  = '0;
        try_clr  = 1'b0;
        try_inc  = 1'b0;
        addr_clr = 1'b0;
        addr_inc = 1'b0;
        ovr_set  = 1'b0;
        ovr_clr  = 1'b0;
        fail     = 1'b0;
        unique case (st)
            S_IDLE: if (start) begin
                nxt = S_RAMP; tmr_load = 1'b1; tmr_val = SET_M1;
                try_clr = 1'b1; addr_clr = 1'b1; ovr_clr = 1'b1;
            end
            S_RAMP: if (tmr_zero) begin
                nxt = S_PSETUP; tmr_load = 1'b1; tmr_val = SET_M1;
            end
            S_PSETUP: if (tmr_zero) begin
                nxt = S_PULSE; tmr_load = 1'b1;
                tmr_val = ovr ? over_m1 : PW_M1;
                try_inc = !ovr;
            end
            S_PULSE: if (tmr_zero) begin
                nxt = S_PHOLD; tmr_load = 1'b1; tmr_val = SET_M1;
            end
            S_PHOLD: if (tmr_zero) begin
                tmr_load = 1'b1;
                if (ovr) begin
                    ovr_clr = 1'b1; tmr_val = SET_M1;
                    if (last) begin
                        nxt = S_RAMPDN;
                    end else begin
                        nxt = S_PSETUP; addr_inc = 1'b1; try_clr = 1'b1;
                    end
                end else begin
                    nxt = S_VERIFY; tmr_val = ACC_M1;
                end
            end
            S_VERIFY: if (tmr_zero) begin
                tmr_load = 1'b1; tmr_val = SET_M1;
                if (match) begin
                    nxt = S_PSETUP; ovr_set = 1'b1;
                end else if (at_cap) begin
                    nxt = S_RAMPDN; fail = 1'b1;
                end else begin
                    nxt = S_PSETUP;
                end
            end
            S_RAMPDN: if (tmr_zero) begin
                if (pass_r) begin
                    nxt = S_RSETTLE; tmr_load = 1'b1; tmr_val = SET_M1;
                    addr_clr = 1'b1;
                end else begin
                    nxt = S_FINISH;
                end
            end
            S_RSETTLE: if (tmr_zero) begin
                nxt = S_RREAD; tmr_load = 1'b1; tmr_val = ACC_M1;
            end
            S_RREAD: if (tmr_zero) begin
                if (!match) begin
                    nxt = S_FINISH; fail = 1'b1;
                end else if (last) begin
                    nxt = S_FINISH;
                end else begin
                    addr_inc = 1'b1; tmr_load = 1'b1; tmr_val = ACC_M1;
                end
            end
            S_FINISH: nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // State, address, over-program flag and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= S_IDLE;
            addr   <= '0;
            ovr    <= 1'b0;
            pass_r <= 1'b0;
        end else begin
            st <= nxt;
            if (addr_clr)      addr <= '0;
            else if (addr_inc) addr <= addr + 1'b1;
            if (ovr_set)       ovr <= 1'b1;
            else if (ovr_clr)  ovr <= 1'b0;
            if (st == S_IDLE && start) pass_r <= 1'b1;
            else if (fail)             pass_r <= 1'b0;
        end
    end

    assign pass = pass_r;

endmodule

// File: rtl/otp_prog_seq.sv
// Top of the OTP write sequencer: converts timing parameters to cycle
// counts, connects timer, attempt counter and state machine, and decodes
// the memory control pins from the state. Assumes src_data is valid in
// the same cycle as src_addr.
module otp_prog_seq
    import otp_seq_pkg::*;
#(
    parameter int DW        = 8,
    parameter int LAST_ADDR = 131071,
    parameter int CLK_KHZ   = 50000,
    parameter int PULSE_NS  = 200000,
    parameter int SETUP_NS  = 2000,
    parameter int ACC_NS    = 150,
    parameter int MAX_TRY   = 25,
    localparam int AW       = (LAST_ADDR > 0) ? $clog2(LAST_ADDR + 1) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          done,
    output logic          pass,
    output logic [AW-1:0] src_addr,
    input  logic [DW-1:0] src_data,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_din,
    input  logic [DW-1:0] mem_dout,
    output logic          mem_data_oe,
    output logic          mem_ce_n,
    output logic          mem_oe_n,
    output logic          mem_pgm_n,
    output logic          hi_supply
);

    localparam int PW_CYC  = ns_to_cycles(CLK_KHZ, PULSE_NS);
    localparam int SET_CYC = ns_to_cycles(CLK_KHZ, SETUP_NS);
    localparam int ACC_CYC = ns_to_cycles(CLK_KHZ, ACC_NS);
    localparam int NW      = $clog2(MAX_TRY + 1);
    localparam int TW      = $clog2(MAX_TRY * PW_CYC + SET_CYC + ACC_CYC + 1);

    seq_state_t    st;
    logic          tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;
    logic          try_clr, try_inc, at_cap;
    logic [NW-1:0] try_cnt;
    logic [AW-1:0] addr;
    logic          match;

    otp_timer #(.W(TW)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    otp_try_ctr #(.MAX_TRY(MAX_TRY), .W(NW)) i_try (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (try_clr),
        .inc    (try_inc),
        .count  (try_cnt),
        .at_cap (at_cap)
    );

    otp_seq_fsm #(
        .AW(AW), .TW(TW), .NW(NW), .LAST_ADDR(LAST_ADDR),
        .PW_CYC(PW_CYC), .SET_CYC(SET_CYC), .ACC_CYC(ACC_CYC)
    ) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .tmr_zero (tmr_zero),
        .at_cap   (at_cap),
        .tries    (try_cnt),
        .match    (match),
        .st       (st),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .try_clr  (try_clr),
        .try_inc  (try_inc),
        .addr     (addr),
        .pass     (pass)
    );

    assign match    = (mem_dout == src_data);
    assign src_addr = addr;
    assign mem_addr = addr;
    assign mem_din  = src_data;
    assign done     = (st == S_FINISH);

    // Pin decode: chip enable, output enable, strobe and supply request.
    always_comb begin
        mem_ce_n    = 1'b1;
        mem_oe_n    = 1'b1;
        mem_pgm_n   = 1'b1;
        mem_data_oe = 1'b0;
        hi_supply   = 1'b0;
        unique case (st)
            S_RAMP, S_RAMPDN: hi_supply = 1'b1;
            S_PSETUP, S_PHOLD: begin
                hi_supply = 1'b1; mem_ce_n = 1'b0; mem_data_oe = 1'b1;
            end
            S_PULSE: begin
                hi_supply = 1'b1; mem_ce_n = 1'b0; mem_data_oe = 1'b1;
                mem_pgm_n = 1'b0;
            end
            S_VERIFY: begin
                hi_supply = 1'b1; mem_ce_n = 1'b0; mem_oe_n = 1'b0;
            end
            S_RREAD: begin
                mem_ce_n = 1'b0; mem_oe_n = 1'b0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/otp_seq_chk.sv
// Property checker for the OTP write sequencer, bound into the top.
module otp_seq_chk #(
    parameter int MAX_TRY = 25,
    parameter int NW      = 5,
    parameter int PW_CYC  = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done,
    input logic          mem_ce_n,
    input logic          mem_oe_n,
    input logic          mem_pgm_n,
    input logic          mem_data_oe,
    input logic          hi_supply,
    input logic [7:0]    mem_din_lo,
    input logic          addr_lo,
    input logic [NW-1:0] try_cnt
);

    int low_cnt;

    // Length of the current run of low strobe cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)          low_cnt <= 0;
        else if (!mem_pgm_n) low_cnt <= low_cnt + 1;
        else                 low_cnt <= 0;
    end

    AST_PULSE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_pgm_n |-> (!mem_ce_n && mem_oe_n && mem_data_oe && hi_supply)); // R3
    AST_PULSE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_pgm_n && !$past(mem_pgm_n)) |-> ($stable(mem_din_lo) && $stable(addr_lo))); // R3
    AST_PULSE_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_pgm_n) |-> (low_cnt >= PW_CYC)); // R5
    AST_READ_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_pgm_n && !mem_data_oe && !mem_ce_n)); // R4
    AST_TRY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        try_cnt <= NW'(MAX_TRY)); // R7
    AST_SUPPLY_CE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(hi_supply) |-> (mem_ce_n && $past(mem_ce_n))); // R8
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

endmodule

bind otp_prog_seq otp_seq_chk #(
    .MAX_TRY (MAX_TRY),
    .NW      (NW),
    .PW_CYC  (PW_CYC)
) i_otp_seq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .done        (done),
    .mem_ce_n    (mem_ce_n),
    .mem_oe_n    (mem_oe_n),
    .mem_pgm_n   (mem_pgm_n),
    .mem_data_oe (mem_data_oe),
    .hi_supply   (hi_supply),
    .mem_din_lo  (8'(mem_din)),
    .addr_lo     (mem_addr[0]),
    .try_cnt     (try_cnt)
);

// File: tb/test_otp_prog_seq.sv
// Scoreboard bench: a driver pushes expected per-byte pulse records,
// a negedge monitor pops and compares them as the sequencer works.
module test_otp_prog_seq;

    localparam int LAST = 7;
    localparam int PW   = 10;   // 200 ns at 50 MHz
    localparam int SU   = 2;    // 40 ns at 50 MHz
    localparam int MAXT = 25;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       done, pass;
    logic [2:0] src_addr, mem_addr;
    logic [7:0] src_data, mem_din, mem_dout;
    logic       mem_data_oe, mem_ce_n, mem_oe_n, mem_pgm_n, hi_supply;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    otp_prog_seq #(
        .DW(8), .LAST_ADDR(LAST), .CLK_KHZ(50000), .PULSE_NS(200),
        .SETUP_NS(40), .ACC_NS(40), .MAX_TRY(MAXT)
    ) i_otp_prog_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done), .pass(pass),
        .src_addr(src_addr), .src_data(src_data), .mem_addr(mem_addr),
        .mem_din(mem_din), .mem_dout(mem_dout), .mem_data_oe(mem_data_oe),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_pgm_n(mem_pgm_n),
        .hi_supply(hi_supply)
    );

    // Memory model: a byte takes its data once it has seen need[] pulses.
    logic [7:0] tgt  [0:LAST];
    int         need [0:LAST];
    logic [7:0] mem  [0:LAST];
    int         pcnt [0:LAST];
    int         corrupt_addr = -1;
    logic       stub_prev;

    assign src_data = tgt[src_addr];
    assign mem_dout = (!mem_ce_n && !mem_oe_n) ?
        (mem[mem_addr] ^ ((!hi_supply && int'(mem_addr) == corrupt_addr) ? 8'h01 : 8'h00)) : 8'h00;

    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i <= LAST; i++) begin mem[i] = 8'hFF; pcnt[i] = 0; end
            stub_prev = 1'b1;
        end else begin
            if (!stub_prev && mem_pgm_n) begin
                pcnt[mem_addr] = pcnt[mem_addr] + 1;
                if (pcnt[mem_addr] >= need[mem_addr]) mem[mem_addr] = mem[mem_addr] & mem_din;
            end
            stub_prev = mem_pgm_n;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    typedef struct { int addr; int pulses; int len; } exp_t;
    exp_t exq[$];
    bit   exp_pass;

    // Monitor state
    bit         prev_pgm_n, prev_done, open, in_rd, done_seen;
    int         cur_len, last_len, pulses, open_addr, setup_cnt, rd_next;
    logic [2:0] prev_addr, rd_last;
    logic [7:0] prev_din;

    task automatic close_entry();
        exp_t e;
        if (exq.size() == 0) begin
            chk(1'b0, "R6 unexpected byte", open_addr, -1);
        end else begin
            e = exq.pop_front();
            chk(open_addr == e.addr, "R2 byte order", open_addr, e.addr);
            chk(pulses == e.pulses, "R5/R6 pulse count", pulses, e.pulses);
            chk(last_len == e.len, "R6 last pulse length", last_len, e.len);
        end
        open = 1'b0;
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_pgm_n = 1'b1; prev_done = 1'b0; open = 1'b0; in_rd = 1'b0;
            setup_cnt = 0; rd_next = 0; done_seen = 1'b0; cur_len = 0; last_len = 0;
        end else begin
            if (!mem_ce_n && src_addr != mem_addr)
                chk(1'b0, "R2 src_addr tracks mem_addr", src_addr, mem_addr);
            if (!mem_pgm_n) begin
                if (prev_pgm_n) begin
                    if (open && int'(mem_addr) != open_addr) close_entry();
                    chk(setup_cnt >= SU, "R3 setup before pulse", setup_cnt, SU);
                    chk(hi_supply, "R2 supply during pulse", hi_supply, 1);
                    if (!open) begin open = 1'b1; open_addr = mem_addr; pulses = 0; end
                    pulses++;
                    cur_len = 0;
                end
                cur_len++;
            end else if (!prev_pgm_n) begin
                last_len = cur_len;
            end
            if (!mem_ce_n && mem_oe_n && mem_pgm_n)
                setup_cnt = (mem_addr == prev_addr && mem_din == prev_din) ? setup_cnt + 1 : 1;
            else if (mem_pgm_n)
                setup_cnt = 0;
            if (!hi_supply && open) close_entry();
            if (!hi_supply && !mem_ce_n && !mem_oe_n) begin
                if (!in_rd || mem_addr != rd_last) begin
                    chk(int'(mem_addr) == rd_next, "R8 final read order", mem_addr, rd_next);
                    rd_next++;
                end
                in_rd = 1'b1; rd_last = mem_addr;
            end else begin
                in_rd = 1'b0;
            end
            if (done) begin
                done_seen = 1'b1;
                chk(pass == exp_pass, "R9 pass at done", pass, exp_pass);
            end
            if (prev_done && done) chk(1'b0, "R9 done one cycle", done, 0);
            prev_done = done; prev_pgm_n = mem_pgm_n; prev_addr = mem_addr; prev_din = mem_din;
        end
    end

    task automatic check_idle(input string tag);
        chk(mem_ce_n && mem_oe_n && mem_pgm_n, {tag, " pins idle"},
            {mem_ce_n, mem_oe_n, mem_pgm_n}, 7);
        chk(!hi_supply && !done, {tag, " supply/done low"}, {hi_supply, done}, 0);
    endtask

    // Driver: reset, push expected records, start, wait for done.
    task automatic run_case(input bit pass_i, input int reads_i);
        int n;
        int guard;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1");
        chk(!pass, "R1 pass low after reset", pass, 0);
        for (int a = 0; a <= LAST; a++) begin
            n = (tgt[a] == 8'hFF) ? 1 : need[a];
            if (n > MAXT) begin
                exq.push_back('{a, MAXT, PW});
                break;
            end
            exq.push_back('{a, n + 1, n * PW});
        end
        exp_pass = pass_i;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (!done_seen && guard < 60000) begin @(negedge clk); guard++; end
        chk(done_seen, "R9 done seen", done_seen, 1);
        repeat (3) @(negedge clk);
        chk(exq.size() == 0, "R6 all bytes programmed", exq.size(), 0);
        chk(rd_next == reads_i, "R8/R7 final read count", rd_next, reads_i);
        chk(pass == pass_i, "R9 pass held", pass, pass_i);
        check_idle("R9 back to idle");
        exq.delete();
    endtask

    initial begin
        // Case A: mixed attempt counts, an erased target, a byte at the cap.
        tgt[0] = 8'h00; need[0] = 1;
        tgt[1] = 8'hFF; need[1] = 7;
        tgt[2] = 8'h5A; need[2] = 2;
        tgt[3] = 8'h3C; need[3] = 25;
        tgt[4] = 8'h0F; need[4] = 3;
        tgt[5] = 8'h81; need[5] = 1;
        tgt[6] = 8'h7E; need[6] = 5;
        tgt[7] = 8'h00; need[7] = 10;
        run_case(1'b1, LAST + 1);
        // Case B: byte 4 needs one attempt beyond the cap (R7).
        for (int a = 0; a <= LAST; a++) need[a] = 2;
        need[4] = 26;
        run_case(1'b0, 0);
        // Case C: byte 5 reads wrong only under read conditions (R9).
        for (int a = 0; a <= LAST; a++) need[a] = 1;
        corrupt_addr = 5;
        run_case(1'b0, 6);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule